// File: doc/BRIEF.md
# Banked General-Purpose Register File with Set Switching

This block holds several complete copies of a 32-entry general-purpose register file and a control word that selects which copy is active. Two combinational read ports and one synchronous write port address the active copy with a 5-bit index. The other copies are not visible at these ports. An exception handler can therefore run in a register set of its own, and the interrupted program's values do not need to be saved or restored.

The active set changes only on an exception-entry strobe or an exception-return strobe. On entry, the outgoing set is remembered as the previous set. The new set is normally the software-programmed exception set. When an interrupt is taken in external-controller mode, the new set is instead the set number supplied by the interrupt controller, and that number is latched into the control word. On return, the previous set becomes active again. Software can read the whole control word, and it can write only the exception-set and previous-set fields.

Top module: `banked_gpr`

## Requirements
- R1: A read returns the register at the given index in the active set. A write updates only that register of the active set, and it is visible on the read ports in the cycle after the write edge.
- R2: Index 0 reads as zero in every set. A write to index 0 has no effect.
- R3: The control word holds the highest set number (NUM_SETS-1) in bits 29:26, the latched external set in bits 21:18, the exception set in bits 15:12, the previous set in bits 9:6 and the active set in bits 3:0. All other bits read as zero.
- R4: Without an entry or return strobe, the active set keeps its value, including across software writes to the control word.
- R5: On exception entry that is not an external-controller interrupt, the previous set takes the old active set and the active set takes the exception set.
- R6: An external-controller interrupt is an entry with the interrupt flag set, a nonzero priority level, the hardware-support flag set and the vectored-interrupt enable set. On such an entry the active set and the latched external set both take the supplied set number, clamped to the highest set. The previous set takes the old active set.
- R7: The latched external set holds its value until the next external-controller interrupt is taken.
- R8: On exception return, the active set takes the previous set and the previous set is unchanged.
- R9: Software writes to the exception-set and previous-set fields are clamped to the highest set. Writes to the other fields are ignored.
- R10: A register write in the same cycle as a set switch lands in the set that was active before the switch.
- R11: After reset, all set fields are zero and every register reads zero.
- R12: When entry and return strobes coincide, entry wins. On entry, the previous-set update overrides a simultaneous software write to that field, and the new active set uses the exception set held before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rd_a_idx_i | input | 5 | Read port A register index |
| rd_a_data_o | output | XLEN | Read port A data |
| rd_b_idx_i | input | 5 | Read port B register index |
| rd_b_data_o | output | XLEN | Read port B data |
| wr_en_i | input | 1 | Register write enable |
| wr_idx_i | input | 5 | Write register index |
| wr_data_i | input | XLEN | Write data |
| exc_enter_i | input | 1 | Exception-entry strobe |
| exc_irq_i | input | 1 | The entering exception is an interrupt |
| exc_return_i | input | 1 | Exception-return strobe |
| eic_hw_i | input | 1 | Hardware supports an external interrupt controller |
| vec_en_i | input | 1 | Software vectored-interrupt enable |
| irq_level_i | input | LVL_W | Priority level of the requested interrupt |
| ext_set_i | input | 4 | Set number proposed by the interrupt controller |
| ctl_we_i | input | 1 | Software control-word write strobe |
| ctl_wdata_i | input | 32 | Software control-word write data |
| ctl_rdata_o | output | 32 | Control-word read data |

## Verification
Read data is combinational from the active set, so a register write or a set switch at clock edge N appears on the read ports after edge N and no later. The control word is registered, and every field change caused by a strobe or a software write at edge N is visible from edge N onward. The bench keeps a behavioural model that it updates at each rising edge from the inputs it has applied. At the following falling edge it compares both read ports and the full control word against that model. This makes every result due exactly one edge after its stimulus, and each result is sampled half a period later.

// File: rtl/bank_pkg.sv
package bank_pkg;
  localparam int SET_W     = 4;
  localparam int HSS_LSB   = 26;
  localparam int EXT_LSB   = 18;
  localparam int ESET_LSB  = 12;
  localparam int PREV_LSB  = 6;
  localparam int CUR_LSB   = 0;

  typedef logic [SET_W-1:0] set_t;

  function automatic set_t clamp_set(input set_t v, input set_t top);
    return (v > top) ? top : v;
  endfunction
endpackage

// File: rtl/bank_read_mux.sv
module bank_read_mux #(
  parameter int XLEN = 32,
  parameter int REGS = 32,
  localparam int IDX_W = $clog2(REGS)
) (
  input  logic [XLEN-1:0]  row_i [REGS],
  input  logic [IDX_W-1:0] idx_i,
  output logic [XLEN-1:0]  data_o
);
  timeunit 1ns; timeprecision 1ps;

  // index 0 is hardwired to zero
  assign data_o = (idx_i == '0) ? '0 : row_i[idx_i];
endmodule

// File: rtl/bank_gpr_store.sv
module bank_gpr_store
  import bank_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REGS     = 32,
  parameter int NUM_SETS = 4,
  parameter int NRD      = 2,
  localparam int IDX_W   = $clog2(REGS),
  localparam int SIDX_W  = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  set_t             set_i,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic [IDX_W-1:0] rd_idx_i  [NRD],
  output logic [XLEN-1:0]  rd_data_o [NRD]
);
  timeunit 1ns; timeprecision 1ps;

  logic [XLEN-1:0]   mem_q  [NUM_SETS][REGS];
  logic [XLEN-1:0]   act_row [REGS];
  logic [SIDX_W-1:0] sel;

  assign sel = set_i[SIDX_W-1:0];

  generate
    if (SIDX_W < SET_W) begin : g_unused_hi
      logic unused_set_hi;
      assign unused_set_hi = ^set_i[SET_W-1:SIDX_W];
    end
  endgenerate

  // set_i is sampled before the edge, so a switching write lands in the old set
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int r = 0; r < REGS; r++)
          mem_q[s][r] <= '0;
    end else if (wr_en_i && (wr_idx_i != '0)) begin
      mem_q[sel][wr_idx_i] <= wr_data_i;
    end
  end

  always_comb begin
    for (int r = 0; r < REGS; r++) act_row[r] = mem_q[sel][r];
  end

  generate
    for (genvar p = 0; p < NRD; p++) begin : g_rd
      bank_read_mux #(.XLEN(XLEN), .REGS(REGS)) u_mux (
        .row_i (act_row),
        .idx_i (rd_idx_i[p]),
        .data_o(rd_data_o[p])
      );
    end
  endgenerate
endmodule

// File: rtl/bank_set_ctl.sv
module bank_set_ctl
  import bank_pkg::*;
#(
  parameter int NUM_SETS = 4,
  parameter int LVL_W    = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             enter_i,
  input  logic             irq_i,
  input  logic             ret_i,
  input  logic             eic_hw_i,
  input  logic             vec_en_i,
  input  logic [LVL_W-1:0] level_i,
  input  set_t             ext_set_i,
  input  logic             we_i,
  input  logic [31:0]      wdata_i,
  output set_t             cur_set_o,
  output logic [31:0]      rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam set_t TOP = set_t'(NUM_SETS - 1);

  set_t cur_q, prev_q, eset_q, ext_q;
  set_t ext_c, eset_wr, prev_wr;
  logic eic_take;
  logic unused_wdata;

  assign eic_take = enter_i & irq_i & eic_hw_i & vec_en_i & (level_i != '0);
  assign ext_c    = clamp_set(ext_set_i, TOP);
  assign eset_wr  = clamp_set(wdata_i[ESET_LSB +: SET_W], TOP);
  assign prev_wr  = clamp_set(wdata_i[PREV_LSB +: SET_W], TOP);
  assign unused_wdata = ^{wdata_i[31:16], wdata_i[11:10], wdata_i[5:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q  <= '0;
      prev_q <= '0;
      eset_q <= '0;
      ext_q  <= '0;
    end else begin
      if (we_i) begin
        eset_q <= eset_wr;
        prev_q <= prev_wr;
      end
      // entry dominates return and the software write to prev
      if (enter_i) begin
        prev_q <= cur_q;
        cur_q  <= eic_take ? ext_c : eset_q;
        if (eic_take) ext_q <= ext_c;
      end else if (ret_i) begin
        cur_q <= prev_q;
      end
    end
  end

  assign cur_set_o = cur_q;

  always_comb begin
    rdata_o = '0;
    rdata_o[HSS_LSB  +: SET_W] = TOP;
    rdata_o[EXT_LSB  +: SET_W] = ext_q;
    rdata_o[ESET_LSB +: SET_W] = eset_q;
    rdata_o[PREV_LSB +: SET_W] = prev_q;
    rdata_o[CUR_LSB  +: SET_W] = cur_q;
  end
endmodule

// File: rtl/banked_gpr.sv
module banked_gpr
  import bank_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int REGS     = 32,
  parameter int NUM_SETS = 4,
  parameter int LVL_W    = 6,
  localparam int IDX_W   = $clog2(REGS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_a_idx_i,
  output logic [XLEN-1:0]  rd_a_data_o,
  input  logic [IDX_W-1:0] rd_b_idx_i,
  output logic [XLEN-1:0]  rd_b_data_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [XLEN-1:0]  wr_data_i,
  input  logic             exc_enter_i,
  input  logic             exc_irq_i,
  input  logic             exc_return_i,
  input  logic             eic_hw_i,
  input  logic             vec_en_i,
  input  logic [LVL_W-1:0] irq_level_i,
  input  logic [3:0]       ext_set_i,
  input  logic             ctl_we_i,
  input  logic [31:0]      ctl_wdata_i,
  output logic [31:0]      ctl_rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam int NRD = 2;

  set_t            cur_set;
  logic [IDX_W-1:0] rd_idx  [NRD];
  logic [XLEN-1:0]  rd_data [NRD];

  assign rd_idx[0]   = rd_a_idx_i;
  assign rd_idx[1]   = rd_b_idx_i;
  assign rd_a_data_o = rd_data[0];
  assign rd_b_data_o = rd_data[1];

  bank_set_ctl #(.NUM_SETS(NUM_SETS), .LVL_W(LVL_W)) u_ctl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .enter_i  (exc_enter_i),
    .irq_i    (exc_irq_i),
    .ret_i    (exc_return_i),
    .eic_hw_i (eic_hw_i),
    .vec_en_i (vec_en_i),
    .level_i  (irq_level_i),
    .ext_set_i(ext_set_i),
    .we_i     (ctl_we_i),
    .wdata_i  (ctl_wdata_i),
    .cur_set_o(cur_set),
    .rdata_o  (ctl_rdata_o)
  );

  bank_gpr_store #(.XLEN(XLEN), .REGS(REGS), .NUM_SETS(NUM_SETS), .NRD(NRD)) u_store (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .set_i    (cur_set),
    .wr_en_i  (wr_en_i),
    .wr_idx_i (wr_idx_i),
    .wr_data_i(wr_data_i),
    .rd_idx_i (rd_idx),
    .rd_data_o(rd_data)
  );
endmodule

// File: rtl/banked_gpr_chk.sv
module banked_gpr_chk #(
  parameter int XLEN     = 32,
  parameter int REGS     = 32,
  parameter int NUM_SETS = 4,
  parameter int LVL_W    = 6,
  localparam int IDX_W   = $clog2(REGS)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [IDX_W-1:0] rd_a_idx_i,
  input logic [XLEN-1:0]  rd_a_data_o,
  input logic [IDX_W-1:0] rd_b_idx_i,
  input logic [XLEN-1:0]  rd_b_data_o,
  input logic             exc_enter_i,
  input logic             exc_irq_i,
  input logic             exc_return_i,
  input logic             eic_hw_i,
  input logic             vec_en_i,
  input logic [LVL_W-1:0] irq_level_i,
  input logic             ctl_we_i,
  input logic [31:0]      ctl_rdata_o
);
  timeunit 1ns; timeprecision 1ps;

  localparam logic [3:0] TOP = 4'(NUM_SETS - 1);

  logic eic_take;
  assign eic_take = exc_enter_i & exc_irq_i & eic_hw_i & vec_en_i & (irq_level_i != '0);

  AST_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {ctl_rdata_o[31:30], ctl_rdata_o[25:22], ctl_rdata_o[17:16], ctl_rdata_o[11:10], ctl_rdata_o[5:4]} == '0); // R3
  AST_TOP_FIXED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[29:26] == TOP); // R3
  AST_SET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !exc_enter_i && !exc_return_i |=> $stable(ctl_rdata_o[3:0])); // R4
  AST_ENTRY_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_enter_i |=> ctl_rdata_o[9:6] == $past(ctl_rdata_o[3:0])); // R5
  AST_EXT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !eic_take |=> $stable(ctl_rdata_o[21:18])); // R7
  AST_RET_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_return_i && !exc_enter_i |=> ctl_rdata_o[3:0] == $past(ctl_rdata_o[9:6])); // R8
  AST_RET_KEEP_PREV: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exc_return_i && !exc_enter_i && !ctl_we_i |=> $stable(ctl_rdata_o[9:6])); // R8
  AST_FIELDS_IN_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_rdata_o[3:0] <= TOP && ctl_rdata_o[9:6] <= TOP &&
    ctl_rdata_o[15:12] <= TOP && ctl_rdata_o[21:18] <= TOP); // R9
  AST_ZERO_A: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_a_idx_i == '0 |-> rd_a_data_o == '0); // R2
  AST_ZERO_B: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_b_idx_i == '0 |-> rd_b_data_o == '0); // R2
endmodule

bind banked_gpr banked_gpr_chk #(
  .XLEN(XLEN), .REGS(REGS), .NUM_SETS(NUM_SETS), .LVL_W(LVL_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .rd_a_idx_i  (rd_a_idx_i),
  .rd_a_data_o (rd_a_data_o),
  .rd_b_idx_i  (rd_b_idx_i),
  .rd_b_data_o (rd_b_data_o),
  .exc_enter_i (exc_enter_i),
  .exc_irq_i   (exc_irq_i),
  .exc_return_i(exc_return_i),
  .eic_hw_i    (eic_hw_i),
  .vec_en_i    (vec_en_i),
  .irq_level_i (irq_level_i),
  .ctl_we_i    (ctl_we_i),
  .ctl_rdata_o (ctl_rdata_o)
);

// File: tb/banked_gpr_tb_top.sv
module banked_gpr_tb_top;
  timeunit 1ns; timeprecision 1ps;

  localparam int NS   = 4;
  localparam int TOPV = NS - 1;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [4:0]  rd_a_idx_i, rd_b_idx_i, wr_idx_i;
  logic [31:0] rd_a_data_o, rd_b_data_o, wr_data_i, ctl_wdata_i, ctl_rdata_o;
  logic        wr_en_i, exc_enter_i, exc_irq_i, exc_return_i, eic_hw_i, vec_en_i, ctl_we_i;
  logic [5:0]  irq_level_i;
  logic [3:0]  ext_set_i;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // behavioural model state
  logic [31:0] m_regs [NS][32];
  int m_cur = 0, m_prev = 0, m_eset = 0, m_ext = 0;

  always #2 clk_i = ~clk_i;

  banked_gpr #(.NUM_SETS(NS)) dut_i (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int clampv(input int v);
    return (v > TOPV) ? TOPV : v;
  endfunction

  function automatic logic [31:0] exp_word();
    logic [31:0] w = '0;
    w[29:26] = 4'(TOPV);
    w[21:18] = 4'(m_ext);
    w[15:12] = 4'(m_eset);
    w[9:6]   = 4'(m_prev);
    w[3:0]   = 4'(m_cur);
    return w;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [4:0] idx);
    return (idx == 0) ? 32'h0 : m_regs[m_cur][idx];
  endfunction

  task automatic model_edge();
    int n_cur = m_cur, n_prev = m_prev, n_eset = m_eset, n_ext = m_ext;
    bit eic = exc_enter_i && exc_irq_i && eic_hw_i && vec_en_i && (irq_level_i != 0);
    if (wr_en_i && wr_idx_i != 0) m_regs[m_cur][wr_idx_i] = wr_data_i;
    if (ctl_we_i) begin
      n_eset = clampv(int'(ctl_wdata_i[15:12]));
      n_prev = clampv(int'(ctl_wdata_i[9:6]));
    end
    if (exc_enter_i) begin
      n_prev = m_cur;
      n_cur  = eic ? clampv(int'(ext_set_i)) : m_eset;
      if (eic) n_ext = clampv(int'(ext_set_i));
    end else if (exc_return_i) begin
      n_cur = m_prev;
    end
    m_cur = n_cur; m_prev = n_prev; m_eset = n_eset; m_ext = n_ext;
  endtask

  task automatic idle();
    wr_en_i = 0; wr_idx_i = 0; wr_data_i = 0;
    exc_enter_i = 0; exc_irq_i = 0; exc_return_i = 0;
    irq_level_i = 0; ext_set_i = 0;
    ctl_we_i = 0; ctl_wdata_i = 0;
  endtask

  // one clock: model follows the edge, outputs compared half a period later
  task automatic step(input string ctl_tag, input string rd_tag);
    @(posedge clk_i);
    model_edge();
    @(negedge clk_i);
    check(ctl_tag, ctl_rdata_o, exp_word());
    check((rd_a_idx_i == 0) ? "R2" : rd_tag, rd_a_data_o, exp_rd(rd_a_idx_i));
    check((rd_b_idx_i == 0) ? "R2" : rd_tag, rd_b_data_o, exp_rd(rd_b_idx_i));
    idle();
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int s = 0; s < NS; s++)
      for (int r = 0; r < 32; r++) m_regs[s][r] = '0;
    idle();
    eic_hw_i = 0; vec_en_i = 0;
    rd_a_idx_i = 3; rd_b_idx_i = 0;
    repeat (3) @(negedge clk_i);
    check("R11", ctl_rdata_o, {2'b0, 4'(TOPV), 26'h0});
    check("R11", rd_a_data_o, 32'h0);
    rst_ni = 1;

    // R1: fill set 0
    for (int r = 1; r < 6; r++) begin
      wr_en_i = 1; wr_idx_i = 5'(r); wr_data_i = 32'(r * 32'h11);
      rd_a_idx_i = 5'(r); rd_b_idx_i = 5'(r - 1);
      step("R4", "R1");
    end
    // R9: read-only fields ignored, in-range write
    ctl_we_i = 1; ctl_wdata_i = {2'b11, 4'hF, 4'hF, 4'h3, 2'b11, 4'h2, 2'b11, 4'h1, 2'b11, 4'h3};
    step("R9", "R1");
    check("R9", ctl_rdata_o[15:12], 32'h2);
    // R9: clamp above top
    ctl_we_i = 1; ctl_wdata_i = 32'h0000_F3C0;
    step("R9", "R1");
    check("R9", ctl_rdata_o[15:12], 32'(TOPV));
    ctl_we_i = 1; ctl_wdata_i = 32'h0000_2040;
    step("R9", "R1");
    // R2: write to index 0
    wr_en_i = 1; wr_idx_i = 0; wr_data_i = 32'hFFFF_FFFF; rd_a_idx_i = 0;
    step("R4", "R2");
    check("R2", rd_a_data_o, 32'h0);
    // R10: write with entry lands in old set 0
    rd_a_idx_i = 5; rd_b_idx_i = 4;
    exc_enter_i = 1; wr_en_i = 1; wr_idx_i = 5; wr_data_i = 32'hDEAD_0005;
    step("R5", "R10");
    check("R5", ctl_rdata_o[3:0], 32'h2);
    check("R10", rd_a_data_o, 32'h0);
    wr_en_i = 1; wr_idx_i = 5; wr_data_i = 32'h2222_2222;
    step("R4", "R1");
    exc_return_i = 1;
    step("R8", "R1");
    check("R10", rd_a_data_o, 32'hDEAD_0005);
    check("R8", ctl_rdata_o[9:6], 32'h0);
    // R6: not EIC without vectored enable
    eic_hw_i = 1;
    exc_enter_i = 1; exc_irq_i = 1; irq_level_i = 3; ext_set_i = 1;
    step("R6", "R1");
    check("R6", ctl_rdata_o[3:0], 32'h2);
    exc_return_i = 1; step("R8", "R1");
    // R6: level zero is not an EIC interrupt
    vec_en_i = 1;
    exc_enter_i = 1; exc_irq_i = 1; irq_level_i = 0; ext_set_i = 1;
    step("R6", "R1");
    check("R6", ctl_rdata_o[21:18], 32'h0);
    exc_return_i = 1; step("R8", "R1");
    // R6: true EIC interrupt
    exc_enter_i = 1; exc_irq_i = 1; irq_level_i = 5; ext_set_i = 1;
    step("R6", "R1");
    check("R6", ctl_rdata_o[3:0], 32'h1);
    check("R6", ctl_rdata_o[21:18], 32'h1);
    // R7: nested plain exception keeps latched external set
    exc_enter_i = 1;
    step("R7", "R1");
    check("R7", ctl_rdata_o[21:18], 32'h1);
    exc_return_i = 1; step("R8", "R1");
    check("R8", ctl_rdata_o[3:0], 32'h1);
    // R6: supplied set clamped
    exc_enter_i = 1; exc_irq_i = 1; irq_level_i = 1; ext_set_i = 9;
    step("R6", "R1");
    check("R6", ctl_rdata_o[3:0], 32'(TOPV));
    // R12: entry with return and software write
    exc_enter_i = 1; exc_return_i = 1; ctl_we_i = 1; ctl_wdata_i = 32'h0000_1000;
    step("R12", "R1");
    check("R12", ctl_rdata_o[9:6], 32'(TOPV));
    check("R12", ctl_rdata_o[3:0], 32'h2);
    check("R12", ctl_rdata_o[15:12], 32'h1);

    // mixed traffic
    for (int i = 0; i < 3000; i++) begin
      int p = $urandom_range(0, 99);
      string t;
      rd_a_idx_i = 5'($urandom); rd_b_idx_i = 5'($urandom);
      wr_en_i = ($urandom_range(0, 1) == 1); wr_idx_i = 5'($urandom); wr_data_i = $urandom;
      vec_en_i = ($urandom_range(0, 3) != 0);
      if (p < 12) begin
        exc_enter_i = 1; exc_irq_i = ($urandom_range(0, 1) == 1);
        irq_level_i = 6'($urandom_range(0, 3)); ext_set_i = 4'($urandom);
      end else if (p < 26) begin
        exc_return_i = 1;
      end else if (p < 34) begin
        ctl_we_i = 1; ctl_wdata_i = $urandom;
      end
      if (p < 3) exc_return_i = 1;
      if (exc_enter_i)
        t = (exc_irq_i && eic_hw_i && vec_en_i && irq_level_i != 0) ? "R6" : "R5";
      else if (exc_return_i) t = "R8";
      else if (ctl_we_i) t = "R9";
      else t = "R4";
      step(t, (wr_en_i && (exc_enter_i || exc_return_i)) ? "R10" : "R1");
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule